// File: doc/BRIEF.md
# Debug Watchpoint Counter Unit

This block sits in a processor's debug logic and holds two 16-bit down-counters. Each counter watches one watchpoint match line. That line is either one of the instruction-fetch watchpoints or one of the load/store watchpoints. Every accepted match moves the counter one step toward its terminal state. When the counter reaches that state, it raises a breakpoint request of the matching kind.

Instruction and load/store breakpoints differ in timing.

- An instruction breakpoint is taken before the triggering instruction executes. The final match does not decrement the counter, so the counter reads one in the handler.
- A load/store breakpoint is taken after the access completes. The final match brings the counter to zero.

Each request is gated by a trap-enable bit. That bit is the OR of two sources:

- a bit written by software through the register port, accepted only in supervisor state;
- a bit loaded serially over the debug port.

Top module: `dbg_wp_counter_unit`

## Requirements
- R1: After reset, both counters, the source configuration, and both trap-enable sets read zero, and `ibp_req` and `lbp_req` are low.
- R2: A counter decrements by exactly one for each accepted pulse on its selected source. Pulses on other sources leave it unchanged.
- R3: While `masked_mode` is 1 and `msr_ri` is 0, pulses are not counted. They are counted when `msr_ri` is 1 or when `masked_mode` is 0.
- R4: For an instruction-type counter, a pulse arriving while the counter holds 1 leaves it at 1. That pulse raises `ibp_req` on the following cycle, provided the trap enable is set.
- R5: For a load/store-type counter, a pulse arriving while the counter holds 1 brings it to 0. That pulse raises `lbp_req` on the following cycle, provided the trap enable is set.
- R6: A counter that has fired ignores further pulses and keeps its request asserted until software writes the counter. Writing a non-zero value clears the request and restarts counting. Writing 0 disables the counter.
- R7: A fired counter k drives a request only while combined enable bit k (software bit OR debug-port bit) is 1.
- R8: A write to the trap-enable register (address 3) updates the software bits only when `msr_pr` is 0. The write is ignored when `msr_pr` is 1.
- R9: Debug-port bits shift in MSB first on `dp_sdi` while `dp_shift` is high. They take effect only on a `dp_update` pulse.
- R10: Address 3 reads the software enable bits in [1:0] and the debug-port enable bits in [3:2]. Addresses 0 and 1 read counters 0 and 1.
- R11: The configuration register (address 2) uses a 3-bit field per counter. Counter 0 uses [2:0] and counter 1 uses [5:3]. In each field, the top bit selects load/store (1) or instruction (0), and the lower two bits give the source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iwp_hit | input | NUM_IWP | Instruction watchpoint match pulses |
| lwp_hit | input | NUM_LWP | Load/store watchpoint match pulses |
| masked_mode | input | 1 | Ignore matches while recoverable-interrupt bit is 0 |
| msr_ri | input | 1 | Processor recoverable-interrupt status bit |
| msr_pr | input | 1 | Processor problem-state bit (1 = user) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data (combinational) |
| dp_shift | input | 1 | Debug-port shift enable |
| dp_sdi | input | 1 | Debug-port serial data in |
| dp_update | input | 1 | Debug-port update strobe |
| ibp_req | output | 1 | Instruction breakpoint request |
| lbp_req | output | 1 | Load/store breakpoint request |

## Verification
Counter values and both breakpoint requests are registered. They change on the first clock edge after a pulse, write, or update strobe. The bench drives every stimulus on a falling edge and holds it through exactly one rising edge. It then samples on the next falling edge, so each result is observed one edge after its cause.

Read data is a combinational function of the address. The bench sets the address on a falling edge and samples a short delay later, before the next rising edge.

// File: rtl/dbg_wp_counter_unit.sv
module dbg_wp_counter_unit #(
  parameter int CNT_W   = 16,
  parameter int NUM_IWP = 4,
  parameter int NUM_LWP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IWP-1:0] iwp_hit,
  input  logic [NUM_LWP-1:0] lwp_hit,
  input  logic               masked_mode,
  input  logic               msr_ri,
  input  logic               msr_pr,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic               dp_shift,
  input  logic               dp_sdi,
  input  logic               dp_update,
  output logic               ibp_req,
  output logic               lbp_req
);
  localparam int NCNT  = 2;
  localparam int MAXS  = (NUM_IWP > NUM_LWP) ? NUM_IWP : NUM_LWP;
  localparam int SEL_W = (MAXS > 1) ? $clog2(MAXS) : 1;
  localparam int FLD_W = SEL_W + 1;
  localparam int CFG_W = NCNT * FLD_W;
  localparam int SRC_N = 1 << SEL_W;

  localparam logic [1:0] A_CFG = 2'd2;
  localparam logic [1:0] A_TE  = 2'd3;

  logic [NCNT-1:0][CNT_W-1:0] cnt_q;
  logic [CFG_W-1:0]           cfg_q;
  logic [NCNT-1:0]            fired_q, sw_te_q, dp_te_q, dp_sh_q;
  logic [NCNT-1:0]            is_ls, bp;
  logic [SRC_N-1:0]           iw_ext, lw_ext;

  wire count_ok = ~masked_mode | msr_ri;
  wire [NCNT-1:0] te_eff = sw_te_q | dp_te_q;

  assign iw_ext = SRC_N'(iwp_hit);
  assign lw_ext = SRC_N'(lwp_hit);

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    wire [FLD_W-1:0] fld   = cfg_q[k*FLD_W +: FLD_W];
    wire [SEL_W-1:0] sel   = fld[SEL_W-1:0];
    wire             hit   = fld[FLD_W-1] ? lw_ext[sel] : iw_ext[sel];
    wire             wr_k  = reg_wr && (reg_addr == 2'(k));
    wire             live  = ~fired_q[k] && (cnt_q[k] != '0);
    wire             evt   = hit && count_ok && live;
    wire             last  = (cnt_q[k] == CNT_W'(1));

    assign is_ls[k] = fld[FLD_W-1];
    assign bp[k]    = fired_q[k] & te_eff[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[k]   <= '0;
        fired_q[k] <= 1'b0;
      end else if (wr_k) begin
        cnt_q[k]   <= reg_wdata;
        fired_q[k] <= 1'b0;
      end else if (evt) begin
        if (last) begin
          fired_q[k] <= 1'b1;
          if (is_ls[k]) cnt_q[k] <= '0;
        end else begin
          cnt_q[k] <= cnt_q[k] - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      sw_te_q <= '0;
      dp_sh_q <= '0;
      dp_te_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata[CFG_W-1:0];
      if (reg_wr && reg_addr == A_TE && !msr_pr) sw_te_q <= reg_wdata[NCNT-1:0];
      if (dp_shift) dp_sh_q <= {dp_sh_q[NCNT-2:0], dp_sdi};
      if (dp_update) dp_te_q <= dp_sh_q;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cnt_q[0];
      2'd1:    reg_rdata = cnt_q[1];
      A_CFG:   reg_rdata = CNT_W'(cfg_q);
      default: reg_rdata = CNT_W'({dp_te_q, sw_te_q});
    endcase
  end

  assign ibp_req = |(bp & ~is_ls);
  assign lbp_req = |(bp & is_ls);
endmodule

module wpc_checker #(parameter int CNT_W = 16) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0][CNT_W-1:0] cnt_q,
  input logic [1:0]           fired_q,
  input logic [1:0]           is_ls,
  input logic [1:0]           sw_te_q,
  input logic [1:0]           dp_te_q,
  input logic                 reg_wr,
  input logic [1:0]           reg_addr,
  input logic                 msr_pr,
  input logic                 dp_update,
  input logic                 ibp_req,
  input logic                 lbp_req
);
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=>
      (cnt_q[0] == $past(cnt_q[0]) || cnt_q[0] == $past(cnt_q[0]) - CNT_W'(1)));

  a_r4_inst_holds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q[0] && !is_ls[0]) |-> cnt_q[0] == CNT_W'(1));

  a_r5_ls_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q[1] && is_ls[1]) |-> cnt_q[1] == '0);

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q[0] && !(reg_wr && reg_addr == 2'd0)) |=> $stable(cnt_q[0]));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ibp_req || lbp_req) |-> |(fired_q & (sw_te_q | dp_te_q)));

  a_r8_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && msr_pr) |=> $stable(sw_te_q));

  a_r9_update_only: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_update |=> $stable(dp_te_q));
endmodule

bind dbg_wp_counter_unit wpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .fired_q(fired_q), .is_ls(is_ls),
  .sw_te_q(sw_te_q), .dp_te_q(dp_te_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .msr_pr(msr_pr), .dp_update(dp_update), .ibp_req(ibp_req), .lbp_req(lbp_req)
);

// File: tb/tb_dbg_wp_counter_unit.sv
module tb_dbg_wp_counter_unit;
  localparam int CLK_P = 10;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic [3:0] iwp_hit = '0;
  logic [1:0] lwp_hit = '0;
  logic masked_mode = 0, msr_ri = 0, msr_pr = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic dp_shift = 0, dp_sdi = 0, dp_update = 0;
  logic ibp_req, lbp_req;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_wp_counter_unit dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [CW-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ipulse(int i);
    @(negedge clk); iwp_hit[i] = 1;
    @(negedge clk); iwp_hit = '0;
  endtask

  task automatic lpulse(int i);
    @(negedge clk); lwp_hit[i] = 1;
    @(negedge clk); lwp_hit = '0;
  endtask

  task automatic dp_load(logic [1:0] v);
    for (int b = 1; b >= 0; b--) begin
      @(negedge clk); dp_shift = 1; dp_sdi = v[b];
    end
    @(negedge clk); dp_shift = 0;
  endtask

  task automatic dp_strobe();
    @(negedge clk); dp_update = 1;
    @(negedge clk); dp_update = 0;
  endtask

  task automatic t_reset();
    logic [CW-1:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reg", d, 0);
    end
    chk("R1 ibp", ibp_req, 0); chk("R1 lbp", lbp_req, 0);
  endtask

  task automatic t_inst();
    logic [CW-1:0] d;
    wr(2, 16'h0021);                 // R11: c0 inst idx1, c1 ls idx0
    rd(2, d); chk("R11 cfg", d, 16'h0021);
    wr(3, 16'h0003);
    wr(0, 3);
    ipulse(1); rd(0, d); chk("R2 dec", d, 2);
    ipulse(0); rd(0, d); chk("R2 other src", d, 2);
    ipulse(1); rd(0, d); chk("R2 dec to 1", d, 1);
    chk("R4 no req yet", ibp_req, 0);
    ipulse(1); rd(0, d); chk("R4 holds one", d, 1);
    chk("R4 ibp", ibp_req, 1); chk("R4 lbp low", lbp_req, 0);
    ipulse(1); rd(0, d); chk("R6 frozen", d, 1);
    chk("R6 req held", ibp_req, 1);
    wr(0, 0); chk("R6 cleared", ibp_req, 0);
    ipulse(1); rd(0, d); chk("R6 disabled", d, 0);
    chk("R6 no req", ibp_req, 0);
  endtask

  task automatic t_ls();
    logic [CW-1:0] d;
    wr(1, 2);
    lpulse(0); rd(1, d); chk("R2 ls dec", d, 1);
    chk("R5 no req yet", lbp_req, 0);
    lpulse(0); rd(1, d); chk("R5 reaches zero", d, 0);
    chk("R5 lbp", lbp_req, 1); chk("R5 ibp low", ibp_req, 0);
    wr(1, 5); chk("R6 reload clears", lbp_req, 0);
    lpulse(0); rd(1, d); chk("R6 restart", d, 4);
  endtask

  task automatic t_mask();
    logic [CW-1:0] d;
    wr(1, 5);
    masked_mode = 1; msr_ri = 0;
    lpulse(0); rd(1, d); chk("R3 masked ri0", d, 5);
    msr_ri = 1;
    lpulse(0); rd(1, d); chk("R3 masked ri1", d, 4);
    masked_mode = 0; msr_ri = 0;
    lpulse(0); rd(1, d); chk("R3 unmasked", d, 3);
  endtask

  task automatic t_te();
    logic [CW-1:0] d;
    wr(3, 0);
    wr(0, 1);
    ipulse(1); chk("R7 gated off", ibp_req, 0);
    msr_pr = 1; wr(3, 1); msr_pr = 0;
    rd(3, d); chk("R8 user ignored", d, 0);
    chk("R8 still gated", ibp_req, 0);
    wr(3, 1);
    rd(3, d); chk("R10 sw bits", d, 1);
    chk("R7 sw enable", ibp_req, 1);
  endtask

  task automatic t_dp();
    logic [CW-1:0] d;
    wr(3, 0); chk("R7 off again", ibp_req, 0);
    dp_load(2'b01);
    rd(3, d); chk("R9 no update yet", d, 0);
    chk("R9 req before update", ibp_req, 0);
    dp_strobe();
    rd(3, d); chk("R10 dp bits", d, 16'h0004);
    chk("R7 dp enable", ibp_req, 1);
    dp_load(2'b10); dp_strobe();
    rd(3, d); chk("R9 msb first", d, 16'h0008);
    chk("R7 dp bit0 gone", ibp_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_inst();
    t_ls();
    t_mask();
    t_te();
    t_dp();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule